// File: doc/BRIEF.md
# Streaming 3x3 Convolution Pipeline

This block convolves one fixed-point feature map, delivered as a raster-ordered pixel stream, with a 3x3 set of coefficients at stride 1. Two line stores keep the two rows above the current one, so a complete 3x3 neighbourhood is available for each accepted pixel. Nine multipliers and a reduction tree of eight adders turn each neighbourhood into one signed sum. Values are 32-bit signed words with 16 fractional bits.

Map width and height are runtime inputs. When the border option is on, the block adds a one-pixel ring of zeros around the map as it streams. It does this by stepping through the ring positions on its own and holding off the input stream while it does. Coefficients are written one at a time through a small index/data port. Each output is flagged valid only when its window lies wholly inside the (possibly bordered) map, and the final output of a map carries an end-of-map flag.

Top module: `conv3x3_stream`

## Requirements
- R1: A coefficient write with `coef_wr_idx` in 0..8 stores `coef_wr_data` as tap `idx = 3*row + col`, where row 0 is the oldest (top) window row and col 0 is the leftmost column. A write with an index of 9 or more changes no coefficient.
- R2: Each tap product is the full 64-bit signed product shifted right arithmetically by 16 and saturated to the 32-bit signed range. The nine saturated products are summed exactly, and the sum is saturated to 32 bits to give `out_data`.
- R3: The result for a window completed by a pixel accepted at clock edge E is presented with `out_valid` high after edge E+2. Each window produces `out_valid` for exactly one cycle.
- R4: With the border off, a W x H map yields exactly (W-2)x(H-2) results in raster order. Result (y,x) is the sum over i,j in 0..2 of K[3i+j] * P(y+i, x+j).
- R5: With the border off, `in_ready` stays high at all times after reset.
- R6: With the border on, a W x H map yields exactly W x H results, computed with P(y+i-1, x+j-1) and with zero for positions outside the map. At each ring position `in_ready` is low for one cycle and no input is consumed. After reset, W+3 such cycles come before the first pixel is taken.
- R7: `out_last` is high together with the final result of each map, and never without `out_valid`.
- R8: While `out_valid` is low, `out_data` keeps its previous value.
- R9: Reset clears `out_valid`, `out_last` and `out_data` to 0 and all coefficients to 0.
- R10: Cycles with `in_valid` low stall the stream without changing any result.
- R11: After the last pixel of a map, the next accepted pixel starts a new map with the same configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_en | input | 1 | Zero-ring border on; hold from reset release |
| cfg_width | input | CW (7) | Map width in pixels |
| cfg_height | input | RW (7) | Map height in rows |
| coef_wr_en | input | 1 | Coefficient write strobe |
| coef_wr_idx | input | 4 | Coefficient tap index |
| coef_wr_data | input | DATA_W (32) | Coefficient value, Q15.16 |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel may be taken |
| in_data | input | DATA_W (32) | Input pixel, Q15.16 |
| out_valid | output | 1 | Result valid |
| out_data | output | DATA_W (32) | Saturated convolution result |
| out_last | output | 1 | Final result of the map |

## Verification
The bench goes after the first two rows of each map, the window positions that wrap across a row edge, and the zero ring, including a 1x1 map with the border on. A design that flagged windows too early or skipped the row-edge check would emit extra results or shift every value by a column. A misplaced ring would leave the ready count after reset wrong, or let the ring consume real pixels. Full-scale positive and negative pixels and coefficients drive both saturation points, where a missing clamp wraps the sign. Stalls from `in_valid` gaps and back-to-back maps catch a design that lets the line stores or counters drift while idle or between maps.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
   localparam int unsigned KDIM    = 3;
   localparam int unsigned TAPS    = KDIM * KDIM;
   localparam int unsigned COEF_IW = 4;

   typedef struct packed {
      logic vld;
      logic last;
   } conv3_tag_t;
endpackage

// File: rtl/conv3_coef_bank.sv
module conv3_coef_bank
   import conv3_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [COEF_IW-1:0]       wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   output logic [TAPS*DATA_W-1:0]   coef_flat
);
   logic [DATA_W-1:0] coef_q [TAPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < TAPS; t++) coef_q[t] <= '0;
      end else if (wr_en && (wr_idx < COEF_IW'(TAPS))) begin
         coef_q[wr_idx] <= wr_data;
      end
   end

   for (genvar gt = 0; gt < TAPS; gt++) begin : g_flat
      assign coef_flat[gt*DATA_W +: DATA_W] = coef_q[gt];
   end
endmodule

// File: rtl/conv3_raster_ctrl.sv
module conv3_raster_ctrl
   import conv3_pkg::*;
#(
   parameter int unsigned CW = 7,
   parameter int unsigned RW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pad_en,
   input  logic [CW-1:0] cfg_width,
   input  logic [RW-1:0] cfg_height,
   input  logic          in_valid,
   output logic          in_ready,
   output logic          adv,
   output logic [CW-1:0] col,
   output conv3_tag_t    tag_q
);
   logic [CW-1:0] vc_q, span_w;
   logic [RW-1:0] vr_q, span_h;
   logic          on_ring, end_col, end_row, full_win;

   assign span_w   = pad_en ? cfg_width  + CW'(2) : cfg_width;
   assign span_h   = pad_en ? cfg_height + RW'(2) : cfg_height;
   assign end_col  = (vc_q == span_w - CW'(1));
   assign end_row  = (vr_q == span_h - RW'(1));
   assign on_ring  = pad_en && ((vc_q == '0) || (vr_q == '0) || end_col || end_row);
   assign full_win = (vc_q >= CW'(KDIM - 1)) && (vr_q >= RW'(KDIM - 1));

   assign in_ready = !on_ring;
   assign adv      = on_ring || in_valid;
   assign col      = vc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vc_q  <= '0;
         vr_q  <= '0;
         tag_q <= '0;
      end else begin
         tag_q.vld  <= adv && full_win;
         tag_q.last <= adv && full_win && end_col && end_row;
         if (adv) begin
            if (end_col) begin
               vc_q <= '0;
               vr_q <= end_row ? '0 : vr_q + RW'(1);
            end else begin
               vc_q <= vc_q + CW'(1);
            end
         end
      end
   end
endmodule

// File: rtl/conv3_window.sv
module conv3_window
   import conv3_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 66,
   parameter int unsigned CW     = 7
) (
   input  logic                   clk,
   input  logic                   adv,
   input  logic [CW-1:0]          col,
   input  logic [DATA_W-1:0]      pix,
   output logic [TAPS*DATA_W-1:0] win_flat
);
   logic [DATA_W-1:0] col_in [KDIM];
   logic [DATA_W-1:0] win_q  [KDIM][KDIM];

   assign col_in[KDIM-1] = pix;

   for (genvar gl = 0; gl < KDIM - 1; gl++) begin : g_line
      logic [DATA_W-1:0] mem [DEPTH];
      assign col_in[KDIM-2-gl] = mem[col];
      always_ff @(posedge clk) begin
         if (adv) mem[col] <= col_in[KDIM-1-gl];
      end
   end

   always_ff @(posedge clk) begin
      if (adv) begin
         for (int r = 0; r < KDIM; r++) begin
            for (int c = 0; c < KDIM - 1; c++) win_q[r][c] <= win_q[r][c+1];
            win_q[r][KDIM-1] <= col_in[r];
         end
      end
   end

   for (genvar gr = 0; gr < KDIM; gr++) begin : g_row
      for (genvar gc = 0; gc < KDIM; gc++) begin : g_col
         assign win_flat[(gr*KDIM+gc)*DATA_W +: DATA_W] = win_q[gr][gc];
      end
   end
endmodule

// File: rtl/conv3_mac_tree.sv
module conv3_mac_tree
   import conv3_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FRAC_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TAPS*DATA_W-1:0] win_flat,
   input  logic [TAPS*DATA_W-1:0] coef_flat,
   input  conv3_tag_t             tag_in,
   output logic [DATA_W-1:0]      out_data,
   output logic                   out_valid,
   output logic                   out_last
);
   localparam int unsigned PROD_W = 2 * DATA_W;
   localparam int unsigned SUM_W  = DATA_W + $clog2(TAPS) + 1;
   localparam logic signed [PROD_W-1:0] P_MAX = {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [PROD_W-1:0] P_MIN = {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
   localparam logic signed [SUM_W-1:0]  S_MAX = {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0]  S_MIN = {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

   logic signed [DATA_W-1:0] sat_p  [TAPS];
   logic signed [DATA_W-1:0] prod_q [TAPS];
   logic signed [SUM_W-1:0]  sum_w;
   logic [DATA_W-1:0]        sum_sat;
   conv3_tag_t               tag_a;

   for (genvar gt = 0; gt < TAPS; gt++) begin : g_mul
      logic signed [DATA_W-1:0] px, kx;
      logic signed [PROD_W-1:0] full, shr;
      assign px   = $signed(win_flat[gt*DATA_W +: DATA_W]);
      assign kx   = $signed(coef_flat[gt*DATA_W +: DATA_W]);
      assign full = PROD_W'(px) * PROD_W'(kx);
      assign shr  = full >>> FRAC_W;
      assign sat_p[gt] = (shr > P_MAX) ? P_MAX[DATA_W-1:0] :
                         (shr < P_MIN) ? P_MIN[DATA_W-1:0] : shr[DATA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < TAPS; t++) prod_q[t] <= '0;
         tag_a <= '0;
      end else begin
         for (int t = 0; t < TAPS; t++) prod_q[t] <= sat_p[t];
         tag_a <= tag_in;
      end
   end

   always_comb begin : tree_sum
      logic signed [SUM_W-1:0] node [2*TAPS];
      node[0] = '0;
      for (int t = 0; t < TAPS; t++)
         node[TAPS+t] = {{(SUM_W-DATA_W){prod_q[t][DATA_W-1]}}, prod_q[t]};
      for (int n = TAPS - 1; n >= 1; n--)
         node[n] = node[2*n] + node[2*n+1];
      sum_w = node[1];
   end

   assign sum_sat = (sum_w > S_MAX) ? S_MAX[DATA_W-1:0] :
                    (sum_w < S_MIN) ? S_MIN[DATA_W-1:0] : sum_w[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
      end else begin
         out_valid <= tag_a.vld;
         out_last  <= tag_a.last;
         if (tag_a.vld) out_data <= sum_sat;
      end
   end
endmodule

// File: rtl/conv3x3_stream.sv
module conv3x3_stream
   import conv3_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FRAC_W     = 16,
   parameter int unsigned MAX_WIDTH  = 64,
   parameter int unsigned MAX_HEIGHT = 64,
   localparam int unsigned CW        = $clog2(MAX_WIDTH + 3),
   localparam int unsigned RW        = $clog2(MAX_HEIGHT + 3),
   localparam int unsigned DEPTH     = MAX_WIDTH + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pad_en,
   input  logic [CW-1:0]      cfg_width,
   input  logic [RW-1:0]      cfg_height,
   input  logic               coef_wr_en,
   input  logic [COEF_IW-1:0] coef_wr_idx,
   input  logic [DATA_W-1:0]  coef_wr_data,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DATA_W-1:0]  in_data,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_last
);
   if (FRAC_W >= DATA_W) begin : g_bad_frac
      $error("FRAC_W must be below DATA_W");
   end
   if (MAX_WIDTH < KDIM || MAX_HEIGHT < KDIM) begin : g_bad_dim
      $error("map limits must cover one full window");
   end

   logic [TAPS*DATA_W-1:0] coef_flat, win_flat;
   logic [CW-1:0]          col;
   logic [DATA_W-1:0]      pix;
   logic                   adv;
   conv3_tag_t             tag_w;

   conv3_coef_bank #(.DATA_W(DATA_W)) u_coef (
      .clk(clk), .rst_n(rst_n), .wr_en(coef_wr_en), .wr_idx(coef_wr_idx),
      .wr_data(coef_wr_data), .coef_flat(coef_flat)
   );

   conv3_raster_ctrl #(.CW(CW), .RW(RW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .cfg_width(cfg_width),
      .cfg_height(cfg_height), .in_valid(in_valid), .in_ready(in_ready),
      .adv(adv), .col(col), .tag_q(tag_w)
   );

   assign pix = in_ready ? in_data : '0;

   conv3_window #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_win (
      .clk(clk), .adv(adv), .col(col), .pix(pix), .win_flat(win_flat)
   );

   conv3_mac_tree #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .win_flat(win_flat), .coef_flat(coef_flat),
      .tag_in(tag_w), .out_data(out_data), .out_valid(out_valid), .out_last(out_last)
   );
endmodule

// File: rtl/conv3x3_stream_chk.sv
module conv3x3_stream_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CW     = 7,
   parameter int unsigned RW     = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pad_en,
   input logic [CW-1:0]     cfg_width,
   input logic [RW-1:0]     cfg_height,
   input logic              in_ready,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_last
);
   int seen_q;
   int want_pad, want_nopad;

   assign want_pad   = int'(cfg_width) * int'(cfg_height);
   assign want_nopad = (int'(cfg_width) - 2) * (int'(cfg_height) - 2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seen_q <= 0;
      else if (out_last) seen_q <= 0;
      else if (out_valid) seen_q <= seen_q + 1;
   end

   always_comb begin
      if (!rst_n) AST_RESET_QUIET: assert (!out_valid && !out_last); // R9
   end

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R7
   AST_READY_NO_RING: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_en |-> in_ready); // R5
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> $stable(out_data)); // R8
   AST_COUNT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_last && !pad_en) |-> (seen_q + 1 == want_nopad)); // R4
   AST_COUNT_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (out_last && pad_en) |-> (seen_q + 1 == want_pad)); // R6
endmodule

bind conv3x3_stream conv3x3_stream_chk #(.DATA_W(DATA_W), .CW(CW), .RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .cfg_width(cfg_width),
   .cfg_height(cfg_height), .in_ready(in_ready), .out_valid(out_valid),
   .out_data(out_data), .out_last(out_last)
);

// File: tb/conv3x3_stream_bench.sv
module conv3x3_stream_bench;
   localparam int DW = 32;
   localparam int MW = 64;
   localparam int MH = 64;
   localparam int CW = $clog2(MW + 3);
   localparam int RW = $clog2(MH + 3);
   localparam longint LMAX = 64'sd2147483647;
   localparam longint LMIN = -64'sd2147483647 - 64'sd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pad_en = 1'b0;
   logic [CW-1:0] cfg_width = CW'(5);
   logic [RW-1:0] cfg_height = RW'(5);
   logic          coef_wr_en = 1'b0;
   logic [3:0]    coef_wr_idx = '0;
   logic [DW-1:0] coef_wr_data = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_data = '0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_last;

   conv3x3_stream u_conv3x3_stream (
      .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .cfg_width(cfg_width),
      .cfg_height(cfg_height), .coef_wr_en(coef_wr_en), .coef_wr_idx(coef_wr_idx),
      .coef_wr_data(coef_wr_data), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
   );

   always #5 clk = ~clk;

   int      checks = 0;
   int      fails = 0;
   longint  cyc = 0;
   int      img [0:399];
   int      kern [0:8];
   int      exp_q [0:399];
   longint  acc_cyc [0:399];
   int      n_exp = 0;
   int      oidx = 0;
   int      cur_w = 5;
   bit      lat_on = 1'b0;
   bit      done = 1'b0;
   logic [DW-1:0] last_data = '0;
   string   cur_req = "R4";

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic longint sat32(input longint v);
      if (v > LMAX) return LMAX;
      if (v < LMIN) return LMIN;
      return v;
   endfunction

   function automatic void compute_exp(input int w, input int h, input bit pad);
      int ow, oh;
      longint s, pv;
      ow = pad ? w : w - 2;
      oh = pad ? h : h - 2;
      n_exp = 0;
      for (int y = 0; y < oh; y++) begin
         for (int x = 0; x < ow; x++) begin
            s = 0;
            for (int i = 0; i < 3; i++) begin
               for (int j = 0; j < 3; j++) begin
                  int yy, xx;
                  yy = pad ? y + i - 1 : y + i;
                  xx = pad ? x + j - 1 : x + j;
                  pv = (yy < 0 || yy >= h || xx < 0 || xx >= w) ? 0 : longint'(img[yy*w+xx]);
                  s += sat32((pv * longint'(kern[i*3+j])) >>> 16);
               end
            end
            exp_q[n_exp] = int'(sat32(s));
            n_exp++;
         end
      end
   endfunction

   // output monitor: values, ordering, end flag, latency, hold
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!pad_en) chk(in_ready, "R5 ready low without border", longint'(in_ready), 1);
         if (out_valid) begin
            if (oidx >= n_exp) begin
               chk(1'b0, {cur_req, " extra result"}, oidx, n_exp);
            end else begin
               chk(out_data == exp_q[oidx], {cur_req, " R2 value"},
                   longint'(out_data), longint'(unsigned'(exp_q[oidx])));
               chk(out_last == (oidx == n_exp - 1), "R7 end flag",
                   longint'(out_last), longint'(oidx == n_exp - 1));
               if (lat_on) begin
                  int src;
                  src = (oidx / (cur_w - 2) + 2) * cur_w + (oidx % (cur_w - 2)) + 2;
                  chk(cyc == acc_cyc[src] + 2, "R3 latency", cyc, acc_cyc[src] + 2);
               end
            end
            oidx++;
            last_data = out_data;
         end else begin
            chk(out_data == last_data, "R8 hold", longint'(out_data), longint'(last_data));
            chk(!out_last, "R7 flag without valid", longint'(out_last), 0);
         end
      end
   end

   task automatic do_reset(input int w, input int h, input bit pad);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      cfg_width = CW'(w);
      cfg_height = RW'(h);
      pad_en = pad;
      cur_w = w;
      n_exp = 0;
      oidx = 0;
      last_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic load_kernel(input int mode);
      for (int t = 0; t < 9; t++) begin
         case (mode)
            0: kern[t] = int'($urandom % (1 << 18)) - (1 << 17);
            1: kern[t] = 32'h7fffffff;
            default: kern[t] = 0;
         endcase
         @(negedge clk);
         coef_wr_en = 1'b1;
         coef_wr_idx = 4'(t);
         coef_wr_data = kern[t];
      end
      // R1: out-of-range indices must not disturb any tap
      for (int t = 9; t < 16; t++) begin
         @(negedge clk);
         coef_wr_idx = 4'(t);
         coef_wr_data = $urandom;
      end
      @(negedge clk);
      coef_wr_en = 1'b0;
   endtask

   task automatic run_frame(input int w, input int h, input bit pad, input int gap,
                            input int fill, input string req);
      int n;
      n = w * h;
      for (int p = 0; p < n; p++) begin
         case (fill)
            0: img[p] = int'($urandom % (1 << 20)) - (1 << 19);
            1: img[p] = 32'h7fffffff;
            default: img[p] = 32'h80000000;
         endcase
      end
      compute_exp(w, h, pad);
      cur_req = req;
      cur_w = w;
      oidx = 0;
      lat_on = !pad;
      for (int p = 0; p < n; p++) begin
         forever begin
            @(negedge clk);
            in_data = img[p];
            in_valid = (int'($urandom % 100) >= gap);
            if (in_valid && in_ready) begin
               acc_cyc[p] = cyc + 1;
               break;
            end
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      for (int k = 0; k < 3000 && oidx < n_exp; k++) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(oidx == n_exp, {req, " result count"}, oidx, n_exp);
   endtask

   task automatic ring_lead(input int w);
      int lows;
      lows = 0;
      while (!in_ready && lows < 1000) begin
         lows++;
         @(negedge clk);
      end
      chk(lows == w + 3, "R6 ring cycles before first pixel", lows, w + 3);
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int t = 0; t < 9; t++) kern[t] = 0;

      // R9: reset state and cleared coefficients
      do_reset(5, 5, 1'b0);
      #1;
      chk(!out_valid, "R9 out_valid after reset", longint'(out_valid), 0);
      chk(!out_last, "R9 out_last after reset", longint'(out_last), 0);
      chk(out_data == '0, "R9 out_data after reset", longint'(out_data), 0);
      chk(in_ready, "R5 ready after reset", longint'(in_ready), 1);
      run_frame(5, 5, 1'b0, 0, 0, "R9 cleared taps");

      // R1 kernel load, R4 plain map, R10 gaps, R11 back to back
      load_kernel(0);
      run_frame(5, 5, 1'b0, 0, 0, "R1 R4");
      run_frame(5, 5, 1'b0, 40, 0, "R10 R11");

      for (int r = 0; r < 4; r++) begin
         int w, h;
         w = 3 + int'($urandom % 10);
         h = 3 + int'($urandom % 6);
         do_reset(w, h, 1'b0);
         load_kernel(0);
         run_frame(w, h, 1'b0, int'($urandom % 50), 0, "R2 R3 R4 R10");
      end
      do_reset(3, 3, 1'b0);
      load_kernel(0);
      run_frame(3, 3, 1'b0, 0, 0, "R4 minimal map");

      // R6 zero ring
      do_reset(4, 3, 1'b1);
      ring_lead(4);
      load_kernel(0);
      run_frame(4, 3, 1'b1, 0, 0, "R6");
      run_frame(4, 3, 1'b1, 30, 0, "R6 R11");
      for (int r = 0; r < 2; r++) begin
         int w, h;
         w = 2 + int'($urandom % 9);
         h = 2 + int'($urandom % 5);
         do_reset(w, h, 1'b1);
         ring_lead(w);
         load_kernel(0);
         run_frame(w, h, 1'b1, int'($urandom % 40), 0, "R6 R10");
      end
      do_reset(1, 1, 1'b1);
      ring_lead(1);
      load_kernel(0);
      run_frame(1, 1, 1'b1, 0, 0, "R6 single pixel");

      // R2 saturation both ways
      do_reset(3, 3, 1'b0);
      load_kernel(1);
      run_frame(3, 3, 1'b0, 0, 1, "R2 positive clamp");
      run_frame(3, 3, 1'b0, 0, 2, "R2 negative clamp");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", oidx, n_exp);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule